// File: doc/BRIEF.md
# Dual-Port Byte-Lane Synchronous RAM

This block is a true dual-port synchronous memory. Each port has its own clock and can read or write any word at any time, including the word the other port is using. Address, write data and controls are sampled on the rising edge of that port's clock. Writes finish at that same edge, so no wait state is needed. Every word is split into two byte lanes. Each lane has its own active-low select, so a port can write or read one lane alone.

Each port has a latency configuration that is captured while reset is held. In flow-through form, read data is presented after the edge that sampled the address. In pipelined form it is presented one edge later. The block does not use tristate pins. Each port returns its read word together with one drive bit per lane. A lane that is not driven reads as zero. An asynchronous output enable withdraws the drive bits at once, without waiting for a clock.

Top module: `dpr_top`

## Requirements
- R1: A port is selected only when its active-low chip select is 0 and its active-high chip select is 1. An unselected port writes nothing, and after its next rising edge both of its drive bits are 0.
- R2: Lane 1 is data bits [17:9] and is controlled by select bit 1. Lane 0 is bits [8:0] and is controlled by select bit 0. A selected write (write strobe 0) updates only the lanes whose select bit is 0. After a write edge the port drives no lane.
- R3: A read at the edge that immediately follows a write to the same word, on the same port, returns the new contents.
- R4: In flow-through form, a selected read (write strobe 1) sampled at edge k shows its data and drive bits after edge k, and they hold until edge k+1.
- R5: In pipelined form, a read sampled at edge k shows its data after edge k+1. Nothing from that read is shown after edge k.
- R6: Only the lanes whose select bit was 0 in the read are driven. An undriven lane reads as zero on the data output. A read with both select bits 1 drives nothing.
- R7: While output enable is 1, both drive bits and the whole data output are 0 immediately, with no clock edge needed. Setting it back to 0 restores the held read at once.
- R8: In pipelined form, a read sampled at edge k is driven after edge k+1 only if the port is also selected at edge k+1. After a deselected edge, two consecutive selected edges are needed before anything is driven again.
- R9: The latency configuration input is captured only while reset is asserted. Changing it afterwards has no effect.
- R10: When one port writes a word and the other port reads it at a coincident edge, the read returns the old contents. A read at the next edge of the reading port returns the new contents.
- R11: During and straight after reset, both ports show drive bits 0 and data 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Active-low reset, asynchronous for the output registers |
| aSelN | input | 1 | Port A chip select, active low |
| aSel | input | 1 | Port A chip select, active high |
| aWriteN | input | 1 | Port A: 0 writes, 1 reads |
| aLaneN | input | 2 | Port A lane selects, active low, bit 1 = upper lane |
| aOutEnN | input | 1 | Port A asynchronous output enable, active low |
| aPipe | input | 1 | Port A latency configuration (1 pipelined), captured in reset |
| aAddr | input | ADDR_W | Port A word address |
| aWrData | input | 18 | Port A write data |
| aRdData | output | 18 | Port A read data, undriven lanes zero |
| aDrive | output | 2 | Port A per-lane drive indication |
| bSelN | input | 1 | Port B chip select, active low |
| bSel | input | 1 | Port B chip select, active high |
| bWriteN | input | 1 | Port B: 0 writes, 1 reads |
| bLaneN | input | 2 | Port B lane selects, active low, bit 1 = upper lane |
| bOutEnN | input | 1 | Port B asynchronous output enable, active low |
| bPipe | input | 1 | Port B latency configuration (1 pipelined), captured in reset |
| bAddr | input | ADDR_W | Port B word address |
| bWrData | input | 18 | Port B write data |
| bRdData | output | 18 | Port B read data, undriven lanes zero |
| bDrive | output | 2 | Port B per-lane drive indication |

## Verification
The bench builds the block with ADDR_W set to 5, which gives 32 words. At that size both the lowest and the highest word can be written and read back within a few cycles, and the lane width stays at its default of 9. Port A is configured flow-through and port B pipelined in the same instance. This lets one run compare both latencies and also read a word from one port while the other port writes it. The two clocks share their edges, so the collision case at a coincident edge, and the case at the next edge, can both be forced on purpose.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
  localparam int unsigned DPR_LANES = 2;
  localparam int unsigned DPR_PORTS = 2;

  // strobes from a port's control to the shared datapath
  typedef struct packed {
    logic [DPR_LANES-1:0] wrMask;   // lanes written at this edge
    logic                 rdStrobe; // read sampled at this edge
    logic                 pipeMode; // captured latency form
    logic [DPR_LANES-1:0] drive;    // lanes presented on the output
  } portStb_t;
endpackage

// File: rtl/dpr_port_ctrl.sv
`timescale 1ns/1ps
module dpr_port_ctrl
  import dpr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 selN,
  input  logic                 sel,
  input  logic                 writeN,
  input  logic [DPR_LANES-1:0] laneN,
  input  logic                 outEnN,
  input  logic                 pipeIn,
  output portStb_t             stb
);
  logic                 chipOn;
  logic                 modeReg;
  logic [DPR_LANES-1:0] laneMask;
  logic [DPR_LANES-1:0] enFlow;
  logic [DPR_LANES-1:0] enPipe;

  assign chipOn   = !selN && sel;
  assign laneMask = ~laneN;

  // latency form is loaded only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= pipeIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enFlow <= '0;
      enPipe <= '0;
    end else begin
      enFlow <= (chipOn && writeN) ? laneMask : '0;
      enPipe <= chipOn ? enFlow : '0;
    end
  end

  always_comb begin
    stb.wrMask   = (chipOn && !writeN) ? laneMask : '0;
    stb.rdStrobe = chipOn && writeN;
    stb.pipeMode = modeReg;
    stb.drive    = (modeReg ? enPipe : enFlow) & {DPR_LANES{!outEnN}};
  end

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeReg && !$past(chipOn)) |-> (stb.drive == '0));

  // R2
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeReg && $past(|stb.wrMask)) |-> (stb.drive == '0));

  // R6
  lane_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeReg |-> ((stb.drive & $past(laneN)) == '0));

  // R5
  pipe_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg && (|stb.drive)) |-> $past(stb.rdStrobe, 2));

  // R8
  pipe_reselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg && (!$past(chipOn) || !$past(chipOn, 2))) |-> (stb.drive == '0));
endmodule

// File: rtl/dpr_datapath.sv
`timescale 1ns/1ps
module dpr_datapath
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 9
) (
  input  logic                          clk    [DPR_PORTS],
  input  logic                          rstN,
  input  portStb_t                      stb    [DPR_PORTS],
  input  logic [ADDR_W-1:0]             addr   [DPR_PORTS],
  input  logic [LANE_W*DPR_LANES-1:0]   wrData [DPR_PORTS],
  output logic [LANE_W*DPR_LANES-1:0]   rdData [DPR_PORTS]
);
  localparam int unsigned DW    = LANE_W * DPR_LANES;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  // each bank has one writer; a word is the XOR of both banks
  logic [DW-1:0] bankA [DEPTH];
  logic [DW-1:0] bankB [DEPTH];

  always_ff @(posedge clk[0]) begin
    for (int l = 0; l < DPR_LANES; l++) begin
      if (stb[0].wrMask[l])
        bankA[addr[0]][l*LANE_W +: LANE_W] <=
          wrData[0][l*LANE_W +: LANE_W] ^ bankB[addr[0]][l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk[1]) begin
    for (int l = 0; l < DPR_LANES; l++) begin
      if (stb[1].wrMask[l])
        bankB[addr[1]][l*LANE_W +: LANE_W] <=
          wrData[1][l*LANE_W +: LANE_W] ^ bankA[addr[1]][l*LANE_W +: LANE_W];
    end
  end

  for (genvar p = 0; p < DPR_PORTS; p++) begin : g_port
    logic [DW-1:0] word;
    logic [DW-1:0] flowQ;
    logic [DW-1:0] pipeQ;
    logic [DW-1:0] shownQ;

    assign word   = bankA[addr[p]] ^ bankB[addr[p]];
    assign shownQ = stb[p].pipeMode ? pipeQ : flowQ;

    always_ff @(posedge clk[p] or negedge rstN) begin
      if (!rstN) begin
        flowQ <= '0;
        pipeQ <= '0;
      end else begin
        if (stb[p].rdStrobe) flowQ <= word;
        pipeQ <= flowQ;
      end
    end

    for (genvar l = 0; l < DPR_LANES; l++) begin : g_lane
      assign rdData[p][l*LANE_W +: LANE_W] =
        stb[p].drive[l] ? shownQ[l*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/dpr_top.sv
`timescale 1ns/1ps
module dpr_top
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 9
) (
  input  logic                        clkA,
  input  logic                        clkB,
  input  logic                        rstN,
  input  logic                        aSelN,
  input  logic                        aSel,
  input  logic                        aWriteN,
  input  logic [1:0]                  aLaneN,
  input  logic                        aOutEnN,
  input  logic                        aPipe,
  input  logic [ADDR_W-1:0]           aAddr,
  input  logic [LANE_W*2-1:0]         aWrData,
  output logic [LANE_W*2-1:0]         aRdData,
  output logic [1:0]                  aDrive,
  input  logic                        bSelN,
  input  logic                        bSel,
  input  logic                        bWriteN,
  input  logic [1:0]                  bLaneN,
  input  logic                        bOutEnN,
  input  logic                        bPipe,
  input  logic [ADDR_W-1:0]           bAddr,
  input  logic [LANE_W*2-1:0]         bWrData,
  output logic [LANE_W*2-1:0]         bRdData,
  output logic [1:0]                  bDrive
);
  localparam int unsigned DW = LANE_W * DPR_LANES;

  logic              clkArr    [DPR_PORTS];
  logic              selNArr   [DPR_PORTS];
  logic              selArr    [DPR_PORTS];
  logic              writeNArr [DPR_PORTS];
  logic [1:0]        laneNArr  [DPR_PORTS];
  logic              outEnNArr [DPR_PORTS];
  logic              pipeArr   [DPR_PORTS];
  logic [ADDR_W-1:0] addrArr   [DPR_PORTS];
  logic [DW-1:0]     wrArr     [DPR_PORTS];
  logic [DW-1:0]     rdArr     [DPR_PORTS];
  portStb_t          stbArr    [DPR_PORTS];

  assign clkArr[0] = clkA;      assign clkArr[1] = clkB;
  assign selNArr[0] = aSelN;    assign selNArr[1] = bSelN;
  assign selArr[0] = aSel;      assign selArr[1] = bSel;
  assign writeNArr[0] = aWriteN; assign writeNArr[1] = bWriteN;
  assign laneNArr[0] = aLaneN;  assign laneNArr[1] = bLaneN;
  assign outEnNArr[0] = aOutEnN; assign outEnNArr[1] = bOutEnN;
  assign pipeArr[0] = aPipe;    assign pipeArr[1] = bPipe;
  assign addrArr[0] = aAddr;    assign addrArr[1] = bAddr;
  assign wrArr[0] = aWrData;    assign wrArr[1] = bWrData;

  for (genvar p = 0; p < DPR_PORTS; p++) begin : g_ctrl
    dpr_port_ctrl i_ctrl (
      .clk    (clkArr[p]),
      .rstN   (rstN),
      .selN   (selNArr[p]),
      .sel    (selArr[p]),
      .writeN (writeNArr[p]),
      .laneN  (laneNArr[p]),
      .outEnN (outEnNArr[p]),
      .pipeIn (pipeArr[p]),
      .stb    (stbArr[p])
    );
  end

  dpr_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_datapath (
    .clk    (clkArr),
    .rstN   (rstN),
    .stb    (stbArr),
    .addr   (addrArr),
    .wrData (wrArr),
    .rdData (rdArr)
  );

  assign aRdData = rdArr[0];
  assign bRdData = rdArr[1];
  assign aDrive  = stbArr[0].drive;
  assign bDrive  = stbArr[1].drive;
endmodule

// File: tb/test_dpr_top.sv
`timescale 1ns/1ps
module test_dpr_top;
  localparam int AW = 5;

  logic clkA = 1'b0, clkB = 1'b0, rstN = 1'b0;
  logic aSelN, aSel, aWriteN, aOutEnN, aPipe;
  logic bSelN, bSel, bWriteN, bOutEnN, bPipe;
  logic [1:0] aLaneN, bLaneN, aDrive, bDrive;
  logic [AW-1:0] aAddr, bAddr;
  logic [17:0] aWrData, bWrData, aRdData, bRdData;
  int nChecks = 0, nErr = 0;
  bit done = 1'b0;

  always #2 begin clkA = ~clkA; clkB = ~clkB; end

  dpr_top #(.ADDR_W(AW), .LANE_W(9)) i_dpr_top (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .aSelN(aSelN), .aSel(aSel), .aWriteN(aWriteN), .aLaneN(aLaneN),
    .aOutEnN(aOutEnN), .aPipe(aPipe), .aAddr(aAddr), .aWrData(aWrData),
    .aRdData(aRdData), .aDrive(aDrive),
    .bSelN(bSelN), .bSel(bSel), .bWriteN(bWriteN), .bLaneN(bLaneN),
    .bOutEnN(bOutEnN), .bPipe(bPipe), .bAddr(bAddr), .bWrData(bWrData),
    .bRdData(bRdData), .bDrive(bDrive)
  );

  typedef struct packed {
    logic        wn;
    logic [1:0]  ln;
    logic [4:0]  addr;
    logic [17:0] din;
    logic [1:0]  expDrv;
    logic [17:0] expDat;
  } vec_t;

  // port A, flow-through, selected, output enable low
  localparam vec_t VECS [13] = '{
    '{1'b0, 2'b00, 5'd3,  {9'h155, 9'h0AA}, 2'b00, 18'h0},              // R2 full write
    '{1'b0, 2'b10, 5'd3,  {9'h1FF, 9'h033}, 2'b00, 18'h0},              // R2 lower only
    '{1'b1, 2'b00, 5'd3,  18'h0,            2'b11, {9'h155, 9'h033}},   // R2 R4
    '{1'b0, 2'b01, 5'd3,  {9'h0F0, 9'h1FF}, 2'b00, 18'h0},              // R2 upper only
    '{1'b1, 2'b00, 5'd3,  18'h0,            2'b11, {9'h0F0, 9'h033}},   // R2 R4
    '{1'b1, 2'b01, 5'd3,  18'h0,            2'b10, {9'h0F0, 9'h000}},   // R6 upper lane
    '{1'b1, 2'b10, 5'd3,  18'h0,            2'b01, {9'h000, 9'h033}},   // R6 lower lane
    '{1'b0, 2'b00, 5'd31, {9'h1AB, 9'h0CD}, 2'b00, 18'h0},              // R2 top word
    '{1'b1, 2'b00, 5'd31, 18'h0,            2'b11, {9'h1AB, 9'h0CD}},   // R3 back to back
    '{1'b1, 2'b11, 5'd31, 18'h0,            2'b00, 18'h0},              // R6 no lane
    '{1'b0, 2'b00, 5'd0,  {9'h001, 9'h100}, 2'b00, 18'h0},              // R2 bottom word
    '{1'b1, 2'b00, 5'd0,  18'h0,            2'b11, {9'h001, 9'h100}},   // R3 R4
    '{1'b1, 2'b00, 5'd3,  18'h0,            2'b11, {9'h0F0, 9'h033}}    // R4
  };

  task automatic tick();
    @(posedge clkA);
    @(negedge clkA);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setA(input logic sn, input logic s, input logic wn,
                      input logic [1:0] ln, input logic [AW-1:0] ad, input logic [17:0] d);
    aSelN = sn; aSel = s; aWriteN = wn; aLaneN = ln; aAddr = ad; aWrData = d;
  endtask

  task automatic setB(input logic sn, input logic s, input logic wn,
                      input logic [1:0] ln, input logic [AW-1:0] ad, input logic [17:0] d);
    bSelN = sn; bSel = s; bWriteN = wn; bLaneN = ln; bAddr = ad; bWrData = d;
  endtask

  initial begin
    setA(1'b1, 1'b0, 1'b1, 2'b11, '0, '0);
    setB(1'b1, 1'b0, 1'b1, 2'b11, '0, '0);
    aOutEnN = 1'b0; bOutEnN = 1'b0;
    aPipe = 1'b0; bPipe = 1'b1;
    repeat (3) tick();
    check("R11 a drive", 32'(aDrive), 0);
    check("R11 a data", 32'(aRdData), 0);
    check("R11 b drive", 32'(bDrive), 0);
    check("R11 b data", 32'(bRdData), 0);
    rstN = 1'b1;
    tick();
    // R9: flip the latency inputs after reset; they must be ignored
    aPipe = 1'b1; bPipe = 1'b0;

    for (int i = 0; i < 13; i++) begin
      setA(1'b0, 1'b1, VECS[i].wn, VECS[i].ln, VECS[i].addr, VECS[i].din);
      tick();
      check($sformatf("R4 vector %0d drive", i), 32'(aDrive), 32'(VECS[i].expDrv));
      check($sformatf("R4 vector %0d data", i), 32'(aRdData), 32'(VECS[i].expDat));
    end

    // R7: asynchronous output enable between edges
    aOutEnN = 1'b1;
    #0.5;
    check("R7 drive off", 32'(aDrive), 0);
    check("R7 data off", 32'(aRdData), 0);
    aOutEnN = 1'b0;
    #0.5;
    check("R7 drive back", 32'(aDrive), 32'h3);
    check("R7 data back", 32'(aRdData), 32'({9'h0F0, 9'h033}));

    // R9: port A still flow-through despite input now 1
    setA(1'b0, 1'b1, 1'b1, 2'b00, 5'd31, '0);
    tick();
    check("R9 a flow kept", 32'(aRdData), 32'({9'h1AB, 9'h0CD}));

    // R1: deselected by either chip select
    setA(1'b1, 1'b1, 1'b0, 2'b00, 5'd31, 18'h3FFFF);
    tick();
    check("R1 low select off drive", 32'(aDrive), 0);
    setA(1'b0, 1'b0, 1'b0, 2'b00, 5'd31, 18'h3FFFF);
    tick();
    check("R1 high select off drive", 32'(aDrive), 0);
    setA(1'b0, 1'b1, 1'b1, 2'b00, 5'd31, '0);
    tick();
    check("R1 no write when off", 32'(aRdData), 32'({9'h1AB, 9'h0CD}));
    setA(1'b1, 1'b0, 1'b1, 2'b11, '0, '0);

    // R5 R8: port B pipelined
    setB(1'b0, 1'b1, 1'b1, 2'b00, 5'd31, '0);
    tick();
    check("R5 R9 nothing after first edge", 32'(bDrive), 0);
    setB(1'b0, 1'b1, 1'b1, 2'b00, 5'd0, '0);
    tick();
    check("R5 drive one edge later", 32'(bDrive), 32'h3);
    check("R5 data one edge later", 32'(bRdData), 32'({9'h1AB, 9'h0CD}));
    setB(1'b0, 1'b1, 1'b1, 2'b10, 5'd3, '0);
    tick();
    check("R5 next word", 32'(bRdData), 32'({9'h001, 9'h100}));
    setB(1'b0, 1'b1, 1'b1, 2'b00, 5'd0, '0);
    tick();
    check("R6 pipelined lower lane drive", 32'(bDrive), 32'h1);
    check("R6 pipelined lower lane data", 32'(bRdData), 32'({9'h000, 9'h033}));
    setB(1'b0, 1'b0, 1'b1, 2'b00, 5'd0, '0);
    tick();
    check("R8 deselect blanks held read", 32'(bDrive), 0);
    setB(1'b0, 1'b1, 1'b1, 2'b00, 5'd31, '0);
    tick();
    check("R8 first selected edge", 32'(bDrive), 0);
    setB(1'b0, 1'b1, 1'b1, 2'b00, 5'd0, '0);
    tick();
    check("R8 second selected edge drive", 32'(bDrive), 32'h3);
    check("R8 second selected edge data", 32'(bRdData), 32'({9'h1AB, 9'h0CD}));
    setB(1'b0, 1'b1, 1'b1, 2'b00, 5'd3, '0);
    tick();
    setB(1'b1, 1'b1, 1'b1, 2'b00, 5'd3, '0);
    tick();
    check("R8 read then deselect", 32'(bDrive), 0);

    // R10: cross-port collision, A writes while B reads
    setA(1'b0, 1'b1, 1'b0, 2'b00, 5'd7, {9'h011, 9'h022});
    setB(1'b0, 1'b1, 1'b1, 2'b00, 5'd5, '0);
    tick();
    setA(1'b0, 1'b1, 1'b0, 2'b00, 5'd7, {9'h1EE, 9'h0DD});
    setB(1'b0, 1'b1, 1'b1, 2'b00, 5'd7, '0);
    tick();
    setA(1'b1, 1'b0, 1'b1, 2'b11, '0, '0);
    tick();
    check("R10 coincident read old", 32'(bRdData), 32'({9'h011, 9'h022}));
    tick();
    check("R10 later read new", 32'(bRdData), 32'({9'h1EE, 9'h0DD}));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clkA);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule